// File: doc/BRIEF.md
# Triggered One-Pulse Timer Channel

This block is a single timer channel that sits idle until a start strobe arrives. It then counts, and it drives one output pulse. The start of the pulse is set by a compare value, and its end by an auto-reload value. The counter can count up or down. A PWM-style compare stage turns the count into a reference level, and a polarity bit maps that level onto the output pin.

In single-shot mode the counter turns itself off at its own rollover, so each start strobe gives exactly one pulse. In repetitive mode it keeps running and repeats the waveform every period. Both the auto-reload and the compare registers can be buffered behind shadow copies, which move into the active registers on an update event. A software update strobe also raises an update event, so the active values can be loaded before arming. A fast-start option drives the output to its matched level on the same edge that starts the counter.

Top module: `opm_timer`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `running_o` is 0, `uev_o` is 0, the count is 0 and `oc_o` equals `cfg_pol_i` (the reference is inactive).
- R2: Counting up without fast start, take T0 as the edge that samples `trig_i` high. `running_o` rises after edge T0+1, and `oc_o` first leaves its idle level after edge T0+2+CMP.
- R3: The reference level follows the count. While counting up, mode 1 (`cfg_mode_i`=0) is active when the count is below the compare value, and mode 2 (`cfg_mode_i`=1) is active when the count is at or above it. While counting up, the pulse lasts ARR−CMP+1 cycles.
- R4: While counting down (`cfg_down_i`=1), mode 2 is active when the count is above the compare value, and mode 1 is active when it is at or below. The output leaves its idle level after edge T0+ARR−CMP+2 and stays away from it for CMP+1 cycles.
- R5: With `cfg_single_i`=1, the counter stops at its wrap. Counting up, the wrap is from ARR to 0; counting down, it is from 0 to ARR. `running_o` is therefore high for ARR+1 cycles.
- R6: With `cfg_single_i`=0, the counter keeps running and wraps every ARR+1 cycles. If the bit is then set, it stops at the next wrap.
- R7: `uev_o` is a one-cycle pulse in the cycle after a wrap edge or after an edge that samples `swupd_i`. A single-shot run shows it once, after edge T0+ARR+2.
- R8: When a preload enable is set, a write to that register changes only its shadow copy, and the active value changes at the next update event. When the enable is clear, the write takes effect at once.
- R9: `swupd_i` reloads the counter, to 0 when counting up and to ARR when counting down. It also moves the shadow copies into the active registers.
- R10: With `cfg_fast_i`=1, the reference takes its compare-match level on edge T0+1, which is the same edge on which `running_o` rises. It holds that level until the next update event.
- R11: `oc_o` is the reference level when `cfg_pol_i`=0, and its inverse when `cfg_pol_i`=1.
- R12: A start strobe that arrives while the counter runs neither restarts nor resets the count, and it does not change the pulse.
- R13: When the compare value equals the starting count, `oc_o` makes no transition during the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Start strobe |
| swupd_i | input | 1 | Software update strobe |
| cfg_mode_i | input | 1 | 0: PWM mode 1, 1: PWM mode 2 |
| cfg_down_i | input | 1 | 0: count up, 1: count down |
| cfg_single_i | input | 1 | 1: stop at the wrap, 0: repetitive |
| cfg_fast_i | input | 1 | Force the matched level on start |
| cfg_pol_i | input | 1 | 0: active high, 1: active low |
| cfg_arr_pre_i | input | 1 | Auto-reload preload enable |
| cfg_cmp_pre_i | input | 1 | Compare preload enable |
| arr_wr_i | input | 1 | Write strobe for auto-reload |
| cmp_wr_i | input | 1 | Write strobe for compare |
| wr_data_i | input | CNT_W | Write data |
| oc_o | output | 1 | Compare output |
| running_o | output | 1 | Counter enabled |
| uev_o | output | 1 | Update-event pulse |

## Verification
Some behaviour is checked by assertions on every cycle. These cover the count stepping by one while a repeated start strobe arrives, the stop on the wrap in single-shot mode, and active registers holding while a preload is pending. They also check that the reference follows the compare result outside a fast hold, and that it holds the matched level during one. Other behaviour shows only in the bench scenarios: the start-to-pulse latency, the pulse width in both count directions, the idle level under each polarity, repetitive running, and the order in which buffered writes take effect across successive runs.

// File: rtl/opm_pkg.sv
package opm_pkg;

    typedef enum logic {
        PWM_MODE1 = 1'b0,
        PWM_MODE2 = 1'b1
    } pwm_mode_e;

    typedef enum logic {
        CNT_UP   = 1'b0,
        CNT_DOWN = 1'b1
    } cnt_dir_e;

    typedef struct packed {
        pwm_mode_e mode;
        cnt_dir_e  dir;
        logic      single;
        logic      fast;
        logic      pol;
    } chan_cfg_t;

    // Reference level from compare results; 1 means active.
    function automatic logic ref_level(pwm_mode_e mode, cnt_dir_e dir,
                                       logic below, logic equal);
        logic lvl2;
        if (dir == CNT_UP) lvl2 = ~below;
        else               lvl2 = ~below & ~equal;
        return (mode == PWM_MODE2) ? lvl2 : ~lvl2;
    endfunction

    // Level the reference takes when the count equals the compare value.
    function automatic logic match_level(pwm_mode_e mode, cnt_dir_e dir);
        return ref_level(mode, dir, 1'b0, 1'b1);
    endfunction

endpackage

// File: rtl/opm_shadow_reg.sv
module opm_shadow_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pre_en_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             load_i,
    output logic [CNT_W-1:0] act_o
);

    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] act_q;
    logic [CNT_W-1:0] act_d;

    always_comb begin
        act_d = act_q;
        if (wr_i && !pre_en_i)  act_d = wdata_i;
        else if (load_i)        act_d = wr_i ? wdata_i : shadow_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            act_q    <= '0;
        end else begin
            if (wr_i) shadow_q <= wdata_i;
            act_q <= act_d;
        end
    end

    assign act_o = act_q;

    // R8: buffered writes leave the active copy alone until an update event
    a_r8_shadow_holds: assert property (@(posedge clk) disable iff (rst)
        (pre_en_i && !load_i) |=> $stable(act_q));

endmodule

// File: rtl/opm_counter.sv
module opm_counter
    import opm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_i,
    input  logic             swupd_i,
    input  cnt_dir_e         dir_i,
    input  logic             single_i,
    input  logic [CNT_W-1:0] arr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             run_o,
    output logic             accept_o,
    output logic             uev_now_o,
    output logic             uev_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             trig_q;
    logic             en_q;
    logic             uev_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] reload_val;
    logic             wrap;
    logic             accept;
    logic             uev_now;

    assign reload_val = (dir_i == CNT_UP) ? '0 : arr_i;
    assign wrap       = (dir_i == CNT_UP) ? (cnt_q == arr_i) : (cnt_q == '0);
    assign accept     = trig_q && !en_q;
    assign uev_now    = (en_q && wrap) || swupd_i;

    always_comb begin
        cnt_d = cnt_q;
        if (swupd_i)                cnt_d = reload_val;
        else if (en_q && wrap)      cnt_d = reload_val;
        else if (en_q)              cnt_d = (dir_i == CNT_UP) ? cnt_q + ONE : cnt_q - ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= 1'b0;
            en_q   <= 1'b0;
            uev_q  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            trig_q <= trig_i;
            uev_q  <= uev_now;
            cnt_q  <= cnt_d;
            if (accept)                        en_q <= 1'b1;
            else if (en_q && wrap && single_i) en_q <= 1'b0;
        end
    end

    assign cnt_o     = cnt_q;
    assign run_o     = en_q;
    assign accept_o  = accept;
    assign uev_now_o = uev_now;
    assign uev_o     = uev_q;

    // R5: single-shot run ends on its wrap
    a_r5_stop_at_wrap: assert property (@(posedge clk) disable iff (rst)
        (en_q && wrap && single_i) |=> !en_q);

    // R12: a start strobe during a run keeps the count stepping normally
    a_r12_retrig_ignored: assert property (@(posedge clk) disable iff (rst)
        (en_q && trig_q && !uev_now && dir_i == CNT_UP) |=> (cnt_q == $past(cnt_q) + ONE));

endmodule

// File: rtl/opm_outstage.sv
module opm_outstage
    import opm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  pwm_mode_e        mode_i,
    input  cnt_dir_e         dir_i,
    input  logic             fast_i,
    input  logic             pol_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             accept_i,
    input  logic             uev_now_i,
    output logic             oc_o
);

    logic cur_lvl;
    logic match_lvl;
    logic hold_q;
    logic hold_d;
    logic ref_q;

    assign cur_lvl   = ref_level(mode_i, dir_i, cnt_i < cmp_i, cnt_i == cmp_i);
    assign match_lvl = match_level(mode_i, dir_i);

    always_comb begin
        hold_d = hold_q;
        if (accept_i && fast_i) hold_d = 1'b1;
        else if (uev_now_i)     hold_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            ref_q  <= 1'b0;
        end else begin
            hold_q <= hold_d;
            ref_q  <= hold_d ? match_lvl : cur_lvl;
        end
    end

    assign oc_o = ref_q ^ pol_i;

    // R3: outside a fast hold the reference is the registered compare result
    a_r3_ref_follows_compare: assert property (@(posedge clk) disable iff (rst)
        (!hold_q && !$past(rst)) |-> (ref_q == $past(cur_lvl)));

    // R10: during a fast hold the reference sits at the matched level
    a_r10_fast_forced: assert property (@(posedge clk) disable iff (rst)
        hold_q |-> (ref_q == $past(match_lvl)));

endmodule

// File: rtl/opm_timer.sv
module opm_timer
    import opm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_i,
    input  logic             swupd_i,
    input  logic             cfg_mode_i,
    input  logic             cfg_down_i,
    input  logic             cfg_single_i,
    input  logic             cfg_fast_i,
    input  logic             cfg_pol_i,
    input  logic             cfg_arr_pre_i,
    input  logic             cfg_cmp_pre_i,
    input  logic             arr_wr_i,
    input  logic             cmp_wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic             oc_o,
    output logic             running_o,
    output logic             uev_o
);

    chan_cfg_t        cfg;
    logic [CNT_W-1:0] arr_act;
    logic [CNT_W-1:0] cmp_act;
    logic [CNT_W-1:0] cnt;
    logic             accept;
    logic             uev_now;

    assign cfg.mode   = pwm_mode_e'(cfg_mode_i);
    assign cfg.dir    = cnt_dir_e'(cfg_down_i);
    assign cfg.single = cfg_single_i;
    assign cfg.fast   = cfg_fast_i;
    assign cfg.pol    = cfg_pol_i;

    opm_shadow_reg #(.CNT_W(CNT_W)) u_arr (
        .clk      (clk),
        .rst      (rst),
        .pre_en_i (cfg_arr_pre_i),
        .wr_i     (arr_wr_i),
        .wdata_i  (wr_data_i),
        .load_i   (uev_now),
        .act_o    (arr_act)
    );

    opm_shadow_reg #(.CNT_W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .pre_en_i (cfg_cmp_pre_i),
        .wr_i     (cmp_wr_i),
        .wdata_i  (wr_data_i),
        .load_i   (uev_now),
        .act_o    (cmp_act)
    );

    opm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .trig_i    (trig_i),
        .swupd_i   (swupd_i),
        .dir_i     (cfg.dir),
        .single_i  (cfg.single),
        .arr_i     (arr_act),
        .cnt_o     (cnt),
        .run_o     (running_o),
        .accept_o  (accept),
        .uev_now_o (uev_now),
        .uev_o     (uev_o)
    );

    opm_outstage #(.CNT_W(CNT_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (cfg.mode),
        .dir_i     (cfg.dir),
        .fast_i    (cfg.fast),
        .pol_i     (cfg.pol),
        .cnt_i     (cnt),
        .cmp_i     (cmp_act),
        .accept_i  (accept),
        .uev_now_i (uev_now),
        .oc_o      (oc_o)
    );

endmodule

// File: tb/opm_timer_bench.sv
module opm_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig_i = 1'b0, swupd_i = 1'b0;
    logic cfg_mode_i = 1'b0, cfg_down_i = 1'b0, cfg_single_i = 1'b1;
    logic cfg_fast_i = 1'b0, cfg_pol_i = 1'b0;
    logic cfg_arr_pre_i = 1'b0, cfg_cmp_pre_i = 1'b0;
    logic arr_wr_i = 1'b0, cmp_wr_i = 1'b0;
    logic [CNT_W-1:0] wr_data_i = '0;
    logic oc_o, running_o, uev_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opm_timer #(.CNT_W(CNT_W)) u_opm_timer (
        .clk(clk), .rst(rst), .trig_i(trig_i), .swupd_i(swupd_i),
        .cfg_mode_i(cfg_mode_i), .cfg_down_i(cfg_down_i),
        .cfg_single_i(cfg_single_i), .cfg_fast_i(cfg_fast_i),
        .cfg_pol_i(cfg_pol_i), .cfg_arr_pre_i(cfg_arr_pre_i),
        .cfg_cmp_pre_i(cfg_cmp_pre_i), .arr_wr_i(arr_wr_i),
        .cmp_wr_i(cmp_wr_i), .wr_data_i(wr_data_i),
        .oc_o(oc_o), .running_o(running_o), .uev_o(uev_o)
    );

    typedef struct packed {
        logic [7:0] arr;
        logic [7:0] cmp;
        logic       mode;
        logic       pol;
        logic       fast;
        logic       down;
        logic       idle;
        int         first;
        int         len;
    } vec_t;

    // arr, cmp, mode, pol, fast, down, idle oc, first deviating sample, deviation length
    localparam vec_t VECS [8] = '{
        '{8'd10, 8'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0,  6,  7},
        '{8'd10, 8'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1,  6,  7},
        '{8'd8,  8'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1,  3,  8},
        '{8'd12, 8'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0,  1, 14},
        '{8'd9,  8'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1,  8,  4},
        '{8'd9,  8'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1,  1, 11},
        '{8'd6,  8'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0,  7,  2},
        '{8'd6,  8'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, -1,  0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic is_arr, input int val);
        wr_data_i = CNT_W'(val);
        if (is_arr) arr_wr_i = 1'b1; else cmp_wr_i = 1'b1;
        @(negedge clk);
        arr_wr_i = 1'b0;
        cmp_wr_i = 1'b0;
    endtask

    task automatic setup(input int arr, input int cmp, input logic mode, input logic pol,
                         input logic fast, input logic down, input logic single);
        cfg_mode_i = mode; cfg_pol_i = pol; cfg_fast_i = fast;
        cfg_down_i = down; cfg_single_i = single;
        cfg_arr_pre_i = 1'b0; cfg_cmp_pre_i = 1'b0;
        write_reg(1'b1, arr);
        write_reg(1'b0, cmp);
        swupd_i = 1'b1;
        @(negedge clk);
        swupd_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Called at a negedge; sample s is taken after edge T0+s.
    task automatic shot(input int n, input int retrig_at, output logic idle,
                        output int first, output int len, output int run_len,
                        output int uev_n, output int uev_at);
        idle = oc_o;
        trig_i = 1'b1;
        @(negedge clk);
        first = -1; len = 0; run_len = 0; uev_n = 0; uev_at = -1;
        for (int s = 0; s < n; s++) begin
            if (s > 0) @(negedge clk);
            trig_i = (s == retrig_at);
            if (oc_o !== idle) begin
                if (first < 0) first = s;
                len++;
            end
            if (running_o) run_len++;
            if (uev_o) begin
                uev_n++;
                if (uev_at < 0) uev_at = s;
            end
        end
        trig_i = 1'b0;
    endtask

    initial begin
        logic idle;
        int first, len, run_len, uev_n, uev_at;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "oc after reset", int'(oc_o), 0);
        chk("R1", "running after reset", int'(running_o), 0);
        chk("R1", "uev after reset", int'(uev_o), 0);

        for (int i = 0; i < 8; i++) begin
            vec_t v;
            string tag_s, tag_w;
            v = VECS[i];
            setup(int'(v.arr), int'(v.cmp), v.mode, v.pol, v.fast, v.down, 1'b1);
            shot(int'(v.arr) + 8, -1, idle, first, len, run_len, uev_n, uev_at);
            if (v.fast)           begin tag_s = "R10"; tag_w = "R10"; end
            else if (v.cmp == 0)  begin tag_s = "R13"; tag_w = "R13"; end
            else if (v.down)      begin tag_s = "R4";  tag_w = "R4";  end
            else                  begin tag_s = "R2";  tag_w = "R3";  end
            chk(v.down ? "R9" : "R11", $sformatf("vec%0d idle level", i), int'(idle), int'(v.idle));
            chk(tag_s, $sformatf("vec%0d pulse start", i), first, v.first);
            chk(tag_w, $sformatf("vec%0d pulse length", i), len, v.len);
            chk("R5", $sformatf("vec%0d running cycles", i), run_len, int'(v.arr) + 1);
            chk("R7", $sformatf("vec%0d update count", i), uev_n, 1);
            chk("R7", $sformatf("vec%0d update position", i), uev_at, int'(v.arr) + 2);
        end

        // R12: second start strobe mid-run
        setup(10, 4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        shot(18, 5, idle, first, len, run_len, uev_n, uev_at);
        chk("R12", "retrig pulse start", first, 6);
        chk("R12", "retrig pulse length", len, 7);
        chk("R12", "retrig running cycles", run_len, 11);
        chk("R12", "retrig update count", uev_n, 1);

        // R6: repetitive running, then stop at the next wrap
        setup(5, 2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        shot(20, -1, idle, first, len, run_len, uev_n, uev_at);
        chk("R6", "repeat update count", uev_n, 3);
        chk("R6", "repeat first update", uev_at, 7);
        chk("R6", "repeat running cycles", run_len, 19);
        cfg_single_i = 1'b1;
        repeat (10) @(negedge clk);
        chk("R6", "stopped after single set", int'(running_o), 0);

        // R8: buffered auto-reload write
        setup(10, 3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        cfg_arr_pre_i = 1'b1;
        write_reg(1'b1, 20);
        shot(26, -1, idle, first, len, run_len, uev_n, uev_at);
        chk("R8", "old reload still active", run_len, 11);
        shot(30, -1, idle, first, len, run_len, uev_n, uev_at);
        chk("R8", "new reload after update", run_len, 21);
        cfg_arr_pre_i = 1'b0;
        write_reg(1'b1, 7);
        shot(16, -1, idle, first, len, run_len, uev_n, uev_at);
        chk("R8", "unbuffered reload immediate", run_len, 8);

        // R8: buffered compare write
        cfg_cmp_pre_i = 1'b1;
        write_reg(1'b0, 5);
        shot(16, -1, idle, first, len, run_len, uev_n, uev_at);
        chk("R8", "old compare start", first, 5);
        chk("R8", "old compare length", len, 5);
        shot(16, -1, idle, first, len, run_len, uev_n, uev_at);
        chk("R8", "new compare start", first, 7);
        chk("R8", "new compare length", len, 3);
        cfg_cmp_pre_i = 1'b0;

        // R7 and R9: software update strobe
        swupd_i = 1'b1;
        @(negedge clk);
        swupd_i = 1'b0;
        chk("R7", "uev after strobe", int'(uev_o), 1);
        @(negedge clk);
        chk("R7", "uev one cycle", int'(uev_o), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule